// File: doc/BRIEF.md
# Interval Timer

A down-counting interval timer attached to a word-addressed register bus. Software programs a period split over two half-width registers, then starts the counter. The counter decrements once per clock while running. When it reaches zero it raises a sticky timeout flag, reloads the period and either keeps running (continuous mode) or halts (one-shot mode). The timeout flag, gated by an enable bit, drives a level interrupt.

Writes use one cycle: `wr_i` high with `addr_i` and `wdata_i` valid, and they take effect at that clock edge. Reads are combinational from `addr_i`. Start and stop are pulses carried by a control write and are not stored. Any write to a snapshot word copies the live count so that software can read it as two halves.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter is stopped, both period words read 16'hFFFF, the timeout flag is clear, control reads 0 and `irq_o` is low.
- R2: Word map: 0 status, 1 control, 2 period bits 15:0, 3 period bits 31:16, 4 snapshot bits 15:0, 5 snapshot bits 31:16, 6 and 7 read zero. Status bit 0 is the timeout flag and bit 1 is running. Control reads back bit 0 (interrupt enable) and bit 1 (continuous), and bits 15:2 read zero.
- R3: While running, the count drops by one each clock. While stopped, it holds its value.
- R4: A write of any value to word 0 clears the timeout flag at that edge, unless a timeout occurs on the same edge, in which case the flag stays set.
- R5: A write to word 2 or word 3 replaces that half of the period, stops the counter and loads the count with the new 32-bit period.
- R6: A running counter at zero sets the timeout flag and reloads the period on the next edge, so timeouts come every period+1 running cycles.
- R7: With control bit 1 set, the counter keeps running after a timeout. With it clear, the counter stops after the timeout.
- R8: A control write with bit 2 set starts a stopped counter from its current count and has no effect on a running one. Bit 3 stops the counter. When both are set, stop wins.
- R9: `irq_o` is high exactly when the timeout flag and control bit 0 are both set, and it drops in the cycle after either is cleared.
- R10: A write of any value to word 4 or word 5 latches the current count. Words 4 and 5 then return bits 15:0 and 31:16 of the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word offset |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench uses the default widths: a 32-bit count split into two 16-bit words. This makes the high period word and the high snapshot word reachable as separate writes and reads. Periods of a few cycles let many continuous reloads and one-shot stops happen within a short run. A nonzero high period word checks that the stop-on-write rule applies to either half. A cycle-level model in the bench predicts the read data at the driven address and the interrupt, and both are compared every clock.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_CTRL   = 1;
  localparam int unsigned OFS_PERIOD = 2;
  localparam int unsigned ST_TO      = 0;
  localparam int unsigned ST_RUN     = 1;
  localparam int unsigned CT_IE      = 0;
  localparam int unsigned CT_CONT    = 1;
  localparam int unsigned CT_START   = 2;
  localparam int unsigned CT_STOP    = 3;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              run_i,
  input  logic              to_i,
  output logic [CNT_W-1:0]  period_nxt_o,
  output logic              ie_o,
  output logic              cont_o,
  output logic              load_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              clr_o,
  output logic [CNT_W-1:0]  snap_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int unsigned NHALF     = CNT_W / REG_W;
  localparam int unsigned SNAP_BASE = OFS_PERIOD + NHALF;

  logic [CNT_W-1:0] period_q;
  logic [NHALF-1:0] per_we, snap_we;
  logic             ctl_we;

  assign ctl_we  = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign clr_o   = wr_i && (addr_i == ADDR_W'(OFS_STATUS));
  assign start_o = ctl_we && wdata_i[CT_START];
  assign stop_o  = ctl_we && wdata_i[CT_STOP];
  assign load_o  = |per_we;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    assign per_we[g]  = wr_i && (addr_i == ADDR_W'(OFS_PERIOD + g));
    assign snap_we[g] = wr_i && (addr_i == ADDR_W'(SNAP_BASE + g));
    assign period_nxt_o[g*REG_W +: REG_W] =
      per_we[g] ? wdata_i : period_q[g*REG_W +: REG_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '1;
      ie_o     <= 1'b0;
      cont_o   <= 1'b0;
      snap_o   <= '0;
    end else begin
      period_q <= period_nxt_o;
      if (ctl_we) begin
        ie_o   <= wdata_i[CT_IE];
        cont_o <= wdata_i[CT_CONT];
      end
      if (|snap_we) snap_o <= count_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_STATUS)) begin
      rdata_o[ST_TO]  = to_i;
      rdata_o[ST_RUN] = run_i;
    end
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rdata_o[CT_IE]   = ie_o;
      rdata_o[CT_CONT] = cont_o;
    end
    for (int i = 0; i < NHALF; i++) begin
      if (addr_i == ADDR_W'(OFS_PERIOD + i)) rdata_o = period_q[i*REG_W +: REG_W];
      if (addr_i == ADDR_W'(SNAP_BASE + i))  rdata_o = snap_o[i*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             load_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clr_i,
  input  logic             cont_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             to_o
);
  logic             expire;
  logic [CNT_W-1:0] cnt_d;
  logic             run_d, to_d;

  assign expire = run_o && (count_o == '0);

  always_comb begin
    cnt_d = count_o;
    run_d = run_o;
    to_d  = to_o;
    if (run_o) cnt_d = expire ? period_i : count_o - 1'b1;
    if (expire && !cont_i) run_d = 1'b0;
    // stop outranks start in the same write
    if (stop_i)       run_d = 1'b0;
    else if (start_i) run_d = 1'b1;
    if (load_i) begin
      cnt_d = period_i;
      run_d = 1'b0;
    end
    if (clr_i)  to_d = 1'b0;
    if (expire) to_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '1;
      run_o   <= 1'b0;
      to_o    <= 1'b0;
    end else begin
      count_o <= cnt_d;
      run_o   <= run_d;
      to_o    <= to_d;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] period_nxt, count_q, snap_q;
  logic             ie_q, cont_q, run_q, to_q;
  logic             load, start, stop, clr;

  timer_regs #(.CNT_W(CNT_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i,
    .count_i(count_q), .run_i(run_q), .to_i(to_q),
    .period_nxt_o(period_nxt), .ie_o(ie_q), .cont_o(cont_q),
    .load_o(load), .start_o(start), .stop_o(stop), .clr_o(clr),
    .snap_o(snap_q), .rdata_o
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .period_i(period_nxt), .load_i(load),
    .start_i(start), .stop_i(stop), .clr_i(clr), .cont_i(cont_q),
    .count_o(count_q), .run_o(run_q), .to_o(to_q)
  );

  assign irq_o = to_q & ie_q;
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  snap_q,
  input logic              run_q,
  input logic              to_q,
  input logic              ie_q,
  input logic              cont_q
);
  logic at_zero;
  assign at_zero = run_q && (count_q == '0);

  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !at_zero && !wr_i |=> count_q == $past(count_q) - 1'b1); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !wr_i |=> $stable(count_q)); // R3
  AST_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == ADDR_W'(0) && !at_zero |=> !to_q); // R4
  AST_PERIOD_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (addr_i == ADDR_W'(2) || addr_i == ADDR_W'(3)) |=> !run_q); // R5
  AST_TO_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |-> $past(at_zero)); // R6
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_zero && !cont_q && !wr_i |=> !run_q); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |-> !irq_o); // R9
  AST_IRQ_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == ADDR_W'(0) && !at_zero |=> !irq_o); // R9
  AST_SNAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == ADDR_W'(4) |=> snap_q == $past(count_q)); // R10
endmodule

bind interval_timer timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .irq_o,
  .count_q, .snap_q, .run_q, .to_q, .ie_q, .cont_q
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  string       tag = "R1";

  // model state
  logic [31:0] m_cnt, m_per, m_snap;
  bit          m_run, m_to, m_ie, m_cont;

  always #2 clk = ~clk;

  interval_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {14'd0, m_run, m_to};
      3'd1: return {14'd0, m_cont, m_ie};
      3'd2: return m_per[15:0];
      3'd3: return m_per[31:16];
      3'd4: return m_snap[15:0];
      3'd5: return m_snap[31:16];
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_tick(input logic [2:0] a, input bit w, input logic [15:0] d);
    bit          hit;
    logic [31:0] c0;
    hit = m_run && (m_cnt == 0);
    c0  = m_cnt;
    if (m_run) m_cnt = hit ? m_per : m_cnt - 1;
    if (hit && !m_cont) m_run = 0;
    if (w) begin
      case (a)
        3'd0: m_to = 0;
        3'd1: begin
          m_ie = d[0]; m_cont = d[1];
          if (d[3]) m_run = 0;
          else if (d[2]) m_run = 1;
        end
        3'd2, 3'd3: begin
          if (a == 3'd2) m_per[15:0] = d; else m_per[31:16] = d;
          m_cnt = m_per; m_run = 0;
        end
        3'd4, 3'd5: m_snap = c0;
        default: ;
      endcase
    end
    if (hit) m_to = 1;
  endtask

  task automatic step(input logic [2:0] a, input bit w, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr = w; wdata = d;
    #1;
    check(tag, 32'(rdata), 32'(exp_read(a)));
    check("R9", 32'(irq), 32'(m_to && m_ie));
    @(posedge clk);
    model_tick(a, w, d);
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) step(a, 0, 16'd0);
  endtask

  initial begin
    m_cnt = '1; m_per = '1; m_snap = '0;
    m_run = 0; m_to = 0; m_ie = 0; m_cont = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    for (int a = 0; a < 6; a++) step(3'(a), 0, 16'd0);
    tag = "R2";
    step(3'd6, 0, 16'd0);
    step(3'd7, 0, 16'd0);
    // short period, continuous, irq enabled
    tag = "R5";
    step(3'd2, 1, 16'd5);
    step(3'd3, 1, 16'd0);
    step(3'd2, 0, 16'd0);
    tag = "R10";
    step(3'd4, 1, 16'hABCD);
    step(3'd4, 0, 16'd0);
    step(3'd5, 0, 16'd0);
    tag = "R8";
    step(3'd1, 1, 16'h0007);
    tag = "R3";
    step(3'd5, 1, 16'd0);
    step(3'd4, 0, 16'd0);
    tag = "R6";
    idle(15, 3'd0);
    tag = "R4";
    step(3'd0, 1, 16'h1234);
    idle(3, 3'd0);
    tag = "R8";
    step(3'd1, 1, 16'h0007);
    step(3'd4, 1, 16'd0);
    step(3'd4, 0, 16'd0);
    // drop enable and continuous: irq falls, one-shot stop
    tag = "R7";
    step(3'd1, 1, 16'h0004);
    idle(10, 3'd0);
    step(3'd4, 1, 16'd0);
    step(3'd4, 0, 16'd0);
    tag = "R4";
    step(3'd0, 1, 16'hFFFF);
    step(3'd0, 0, 16'd0);
    // both start and stop: stop wins
    tag = "R8";
    step(3'd1, 1, 16'h000D);
    idle(3, 3'd0);
    step(3'd1, 1, 16'h0006);
    idle(4, 3'd0);
    // high period write while running stops and reloads
    tag = "R5";
    step(3'd3, 1, 16'h0001);
    idle(3, 3'd0);
    step(3'd3, 0, 16'd0);
    step(3'd4, 1, 16'd0);
    step(3'd5, 0, 16'd0);
    step(3'd4, 0, 16'd0);
    tag = "R2";
    step(3'd1, 1, 16'hFFF3);
    step(3'd1, 0, 16'd0);
    step(3'd0, 0, 16'd0);
    step(3'd3, 1, 16'd0);
    step(3'd2, 1, 16'd2);
    step(3'd1, 1, 16'h0007);
    tag = "R9";
    idle(12, 3'd0);
    step(3'd1, 1, 16'h0002);
    idle(2, 3'd1);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule